// File: doc/BRIEF.md
# Prioritised Interrupt and Vector Unit

This unit decides when a processor core leaves its instruction stream to service an exception or an interrupt, and which table entry it then uses. It watches a three-bit encoded pending level and compares it against the mask held in a small status word (supervisor flag plus three mask bits). It also accepts synchronous requests from the core, namely a generic internal fault with its own vector and a software trap with a four-bit number. Everything is sampled only at instruction boundaries.

Once an external level is accepted, the unit runs an acknowledge phase. The responder returns a device-supplied vector, asks for the autovector for that level, or gives no response, in which case the spurious vector is used. The status word in force before acceptance is offered to the core on a stack-push handshake. Only after that push completes is the vector number and its byte address in the vector table presented for one cycle. Acceptance always sets the supervisor flag, which also selects the supervisor stack pointer. A return-from-exception input restores a status word popped by the core. After reset the unit presents the two boot vectors, first the one for the stack pointer and then the one for the program counter.

Top module: `piv_unit`

## Requirements
- R1: During reset, vec_valid_o is 0, sup_o is 1 and mask_o is 7. The first clock after reset release presents vector 0, the second presents vector 1, each with vec_valid_o high for one cycle, and the unit is then idle.
- R2: A pending level 1 to 6 is accepted at a boundary only when it is greater than mask_o. In the cycle after acceptance, ack_o is high and ack_lvl_o carries the level. A level at or below the mask leaves ack_o low.
- R3: Level 7 is accepted regardless of the mask, but only if ipl_i has been seen at a value other than 7 since the last level-7 acceptance (and since reset). A held level 7 is not taken again.
- R4: On interrupt acceptance, mask_o becomes the accepted level and sup_o becomes 1 in the next cycle. push_sr_o presents the status word from before acceptance, as {sup, mask[2:0]} with sup in bit 3.
- R5: In the acknowledge phase the response priority is ack_vec_i, then ack_auto_i, then ack_none_i. They yield, in that order, vector ack_vnum_i, vector 24 plus the level, and vector 24 (spurious).
- R6: vec_addr_o equals vec_num_o times 4 whenever vec_valid_o is high.
- R7: A trap request with number n yields vector 32 plus n. It leaves the mask unchanged, sets sup_o and goes straight to the push phase with no acknowledge.
- R8: When several requests meet at a boundary, the internal fault (vector exc_vec_i) wins over a trap, and a trap wins over an external level.
- R9: No request is taken while boundary_i is low.
- R10: rte_i in the idle state loads the status word from rte_sr_i (bit 3 supervisor, bits 2:0 mask) on the next edge. Any request in that same cycle is not taken.
- R11: ssp_sel_o follows sup_o and is high throughout the acknowledge and push phases.
- R12: push_req_o stays high until push_done_i. The vector is presented in the cycle after push_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_i | input | 3 | Encoded pending interrupt level, 0 = none |
| boundary_i | input | 1 | Core is at an instruction boundary |
| exc_req_i | input | 1 | Internal fault request |
| exc_vec_i | input | 8 | Vector for the internal fault |
| trap_req_i | input | 1 | Software trap request |
| trap_num_i | input | 4 | Trap number |
| rte_i | input | 1 | Return from exception |
| rte_sr_i | input | 4 | Status word to restore {sup, mask} |
| ack_o | output | 1 | Acknowledge phase active |
| ack_lvl_o | output | 3 | Level being acknowledged |
| ack_vec_i | input | 1 | Responder supplies a vector |
| ack_vnum_i | input | 8 | Supplied vector number |
| ack_auto_i | input | 1 | Responder requests the autovector |
| ack_none_i | input | 1 | No responder (spurious) |
| push_req_o | output | 1 | Request to push the exception frame |
| push_sr_o | output | 4 | Saved status word for the frame |
| push_done_i | input | 1 | Frame push complete |
| vec_valid_o | output | 1 | Vector number and address valid |
| vec_num_o | output | 8 | Vector number |
| vec_addr_o | output | 10 | Byte address of the vector entry |
| sup_o | output | 1 | Supervisor flag |
| ssp_sel_o | output | 1 | Supervisor stack pointer selected |
| mask_o | output | 3 | Current interrupt mask |

## Verification
The assertions take for granted that the core and responder keep to the handshake. An acknowledge response arrives only while ack_o is high, push_done_i comes only while push_req_o is high, and rte_i is raised only when the unit is idle. The bench changes every input on the falling edge and raises each response only in the phase that expects it. Where a level-7 sequence depends on it, the bench drives ipl_i back to 0 so the edge history is known. Combined requests are applied in one idle cycle, so that the ordering rules are exercised without breaking the handshake.

// File: rtl/piv_pkg.sv
package piv_pkg;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int ADDR_W    = VEC_W + 2;
  localparam int TRAP_W    = 4;
  localparam int SPUR_VEC  = 24;
  localparam int AUTO_BASE = 24;
  localparam int TRAP_BASE = 32;
  localparam int SR_W      = LVL_W + 1;

  typedef struct packed {
    logic             sup;
    logic [LVL_W-1:0] mask;
  } stat_t;

  typedef enum logic [2:0] {
    ST_START, ST_RV0, ST_RV1, ST_IDLE, ST_ACK, ST_PUSH, ST_VEC
  } st_e;
endpackage

// File: rtl/piv_arb.sv
module piv_arb #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             nmi_taken_i,
  output logic             take_o
);
  localparam logic [LVL_W-1:0] NMI = '1;

  logic armed_q;

  // top level is edge triggered: re-armed only once the line leaves it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (nmi_taken_i) armed_q <= 1'b0;
    else if (ipl_i != NMI) armed_q <= 1'b1;
  end

  always_comb take_o = (ipl_i == NMI) ? armed_q : (ipl_i > mask_i);

  p_nmi_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_i == NMI && $past(ipl_i) == NMI && $past(nmi_taken_i)) |-> !take_o);
endmodule

// File: rtl/piv_vecmap.sv
module piv_vecmap #(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int TRAP_W    = 4,
  parameter int SPUR_VEC  = 24,
  parameter int AUTO_BASE = 24,
  parameter int TRAP_BASE = 32
) (
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  input  logic              ack_vec_i,
  input  logic [VEC_W-1:0]  ack_vnum_i,
  input  logic              ack_auto_i,
  input  logic [VEC_W-1:0]  vnum_i,
  output logic [VEC_W-1:0]  ack_sel_o,
  output logic [VEC_W-1:0]  trap_vnum_o,
  output logic [VEC_W+1:0]  addr_o
);
  always_comb begin
    if (ack_vec_i)       ack_sel_o = ack_vnum_i;
    else if (ack_auto_i) ack_sel_o = VEC_W'(AUTO_BASE) + VEC_W'(lvl_i);
    else                 ack_sel_o = VEC_W'(SPUR_VEC);
  end

  always_comb trap_vnum_o = VEC_W'(TRAP_BASE) + VEC_W'(trap_num_i);
  always_comb addr_o      = {vnum_i, 2'b00};
endmodule

// File: rtl/piv_unit.sv
module piv_unit
  import piv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic              boundary_i,
  input  logic              exc_req_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic              trap_req_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  input  logic              rte_i,
  input  logic [SR_W-1:0]   rte_sr_i,
  output logic              ack_o,
  output logic [LVL_W-1:0]  ack_lvl_o,
  input  logic              ack_vec_i,
  input  logic [VEC_W-1:0]  ack_vnum_i,
  input  logic              ack_auto_i,
  input  logic              ack_none_i,
  output logic              push_req_o,
  output logic [SR_W-1:0]   push_sr_o,
  input  logic              push_done_i,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              sup_o,
  output logic              ssp_sel_o,
  output logic [LVL_W-1:0]  mask_o
);
  localparam logic [LVL_W-1:0] NMI = '1;

  st_e              st_q;
  stat_t            stat_q, saved_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vnum_q, ack_sel, trap_vnum;
  logic             take, sample, go_exc, go_trap, go_irq, nmi_taken, ack_resp;

  always_comb begin
    sample    = (st_q == ST_IDLE) && boundary_i && !rte_i;
    go_exc    = sample && exc_req_i;
    go_trap   = sample && !exc_req_i && trap_req_i;
    go_irq    = sample && !exc_req_i && !trap_req_i && take;
    nmi_taken = go_irq && (ipl_i == NMI);
    ack_resp  = ack_vec_i || ack_auto_i || ack_none_i;
  end

  piv_arb #(.LVL_W(LVL_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ipl_i       (ipl_i),
    .mask_i      (stat_q.mask),
    .nmi_taken_i (nmi_taken),
    .take_o      (take)
  );

  piv_vecmap #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .TRAP_W(TRAP_W),
    .SPUR_VEC(SPUR_VEC), .AUTO_BASE(AUTO_BASE), .TRAP_BASE(TRAP_BASE)
  ) u_map (
    .lvl_i       (lvl_q),
    .trap_num_i  (trap_num_i),
    .ack_vec_i   (ack_vec_i),
    .ack_vnum_i  (ack_vnum_i),
    .ack_auto_i  (ack_auto_i),
    .vnum_i      (vec_num_o),
    .ack_sel_o   (ack_sel),
    .trap_vnum_o (trap_vnum),
    .addr_o      (vec_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_START;
      stat_q  <= '{sup: 1'b1, mask: '1};
      saved_q <= '0;
      lvl_q   <= '0;
      vnum_q  <= '0;
    end else begin
      unique case (st_q)
        ST_START: st_q <= ST_RV0;
        ST_RV0:   st_q <= ST_RV1;
        ST_RV1:   st_q <= ST_IDLE;
        ST_IDLE: begin
          if (rte_i) begin
            stat_q <= stat_t'(rte_sr_i);
          end else if (go_exc || go_trap) begin
            saved_q    <= stat_q;
            stat_q.sup <= 1'b1;
            vnum_q     <= go_exc ? exc_vec_i : trap_vnum;
            st_q       <= ST_PUSH;
          end else if (go_irq) begin
            saved_q <= stat_q;
            stat_q  <= '{sup: 1'b1, mask: ipl_i};
            lvl_q   <= ipl_i;
            st_q    <= ST_ACK;
          end
        end
        ST_ACK: if (ack_resp) begin
          vnum_q <= ack_sel;
          st_q   <= ST_PUSH;
        end
        ST_PUSH:  if (push_done_i) st_q <= ST_VEC;
        ST_VEC:   st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ack_o       = (st_q == ST_ACK);
    ack_lvl_o   = lvl_q;
    push_req_o  = (st_q == ST_PUSH);
    push_sr_o   = saved_q;
    vec_valid_o = (st_q == ST_RV0) || (st_q == ST_RV1) || (st_q == ST_VEC);
    unique case (st_q)
      ST_RV0:  vec_num_o = '0;
      ST_RV1:  vec_num_o = VEC_W'(1);
      default: vec_num_o = vnum_q;
    endcase
    sup_o     = stat_q.sup;
    ssp_sel_o = stat_q.sup;
    mask_o    = stat_q.mask;
  end

  p_ack_lvl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_irq |=> ack_o && ack_lvl_o == $past(ipl_i) && mask_o == $past(ipl_i) && sup_o);

  p_blocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && boundary_i && !rte_i && !exc_req_i && !trap_req_i &&
     ipl_i != NMI && ipl_i <= mask_o) |=> !ack_o);

  p_save_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> push_sr_o == $past({sup_o, mask_o}));

  p_no_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !boundary_i && !rte_i) |=>
      !ack_o && !push_req_o && $stable({sup_o, mask_o}));

  p_rte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && rte_i) |=> {sup_o, mask_o} == $past(rte_sr_i) && !push_req_o && !ack_o);

  p_ssp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || push_req_o) |-> ssp_sel_o);

  p_push_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_o && !push_done_i) |=> push_req_o && !vec_valid_o);

  p_vec_after_push_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_o && push_done_i) |=> vec_valid_o && !push_req_o);
endmodule

// File: tb/sim_piv_unit.sv
module sim_piv_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ipl_i = '0;
  logic       boundary_i = 1'b0, exc_req_i = 1'b0, trap_req_i = 1'b0, rte_i = 1'b0;
  logic [7:0] exc_vec_i = '0, ack_vnum_i = '0;
  logic [3:0] trap_num_i = '0, rte_sr_i = '0;
  logic       ack_vec_i = 1'b0, ack_auto_i = 1'b0, ack_none_i = 1'b0, push_done_i = 1'b0;
  logic       ack_o, push_req_o, vec_valid_o, sup_o, ssp_sel_o;
  logic [2:0] ack_lvl_o, mask_o;
  logic [3:0] push_sr_o;
  logic [7:0] vec_num_o;
  logic [9:0] vec_addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  piv_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ipl_i(ipl_i), .boundary_i(boundary_i),
    .exc_req_i(exc_req_i), .exc_vec_i(exc_vec_i), .trap_req_i(trap_req_i),
    .trap_num_i(trap_num_i), .rte_i(rte_i), .rte_sr_i(rte_sr_i),
    .ack_o(ack_o), .ack_lvl_o(ack_lvl_o), .ack_vec_i(ack_vec_i),
    .ack_vnum_i(ack_vnum_i), .ack_auto_i(ack_auto_i), .ack_none_i(ack_none_i),
    .push_req_o(push_req_o), .push_sr_o(push_sr_o), .push_done_i(push_done_i),
    .vec_valid_o(vec_valid_o), .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o),
    .sup_o(sup_o), .ssp_sel_o(ssp_sel_o), .mask_o(mask_o)
  );

  // lvl, mask, resp {vec,auto,none}, supplied vector, taken, expected vector
  typedef struct packed {
    logic [2:0] lvl;
    logic [2:0] mask;
    logic [2:0] resp;
    logic [7:0] avn;
    logic       take;
    logic [7:0] evn;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{3'd3, 3'd2, 3'b010, 8'h00, 1'b1, 8'd27},
    '{3'd5, 3'd5, 3'b000, 8'h00, 1'b0, 8'd0},
    '{3'd6, 3'd0, 3'b100, 8'h40, 1'b1, 8'd64},
    '{3'd2, 3'd1, 3'b001, 8'h00, 1'b1, 8'd24},
    '{3'd1, 3'd0, 3'b111, 8'h80, 1'b1, 8'd128},
    '{3'd4, 3'd6, 3'b000, 8'h00, 1'b0, 8'd0},
    '{3'd0, 3'd0, 3'b000, 8'h00, 1'b0, 8'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_rte(input logic [3:0] sr);
    @(negedge clk);
    rte_i = 1'b1; rte_sr_i = sr;
    tick();
    @(negedge clk);
    rte_i = 1'b0;
  endtask

  task automatic finish_vec(input logic [7:0] ev, input string tag);
    @(negedge clk);
    push_done_i = 1'b1;
    tick();
    chk(vec_valid_o === 1'b1, {tag, " vec_valid"}, vec_valid_o, 1);
    chk(vec_num_o === ev, {tag, " vec_num"}, vec_num_o, ev);
    chk(vec_addr_o === {ev, 2'b00}, "R6 vec_addr", vec_addr_o, {ev, 2'b00});
    @(negedge clk);
    push_done_i = 1'b0;
    tick();
    chk(vec_valid_o === 1'b0, {tag, " vec one cycle"}, vec_valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset and boot vectors
    repeat (3) @(posedge clk);
    #1;
    chk(vec_valid_o === 1'b0, "R1 no vec in reset", vec_valid_o, 0);
    chk(sup_o === 1'b1 && mask_o === 3'd7, "R1 reset status", {sup_o, mask_o}, 4'hf);
    @(negedge clk);
    rst_ni = 1'b1;
    tick();
    chk(vec_valid_o === 1'b1 && vec_num_o === 8'd0 && vec_addr_o === 10'd0, "R1 boot sp vector", vec_num_o, 0);
    tick();
    chk(vec_valid_o === 1'b1 && vec_num_o === 8'd1 && vec_addr_o === 10'd4, "R1 boot pc vector", vec_addr_o, 4);
    tick();
    chk(vec_valid_o === 1'b0, "R1 idle after boot", vec_valid_o, 0);
    chk(sup_o === 1'b1 && mask_o === 3'd7, "R1 status after boot", {sup_o, mask_o}, 4'hf);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_rte({1'b0, TBL[i].mask});
      @(negedge clk);
      ipl_i = TBL[i].lvl; boundary_i = 1'b1;
      tick();
      if (TBL[i].take) begin
        chk(ack_o === 1'b1 && ack_lvl_o === TBL[i].lvl, "R2 ack level", {ack_o, ack_lvl_o}, {1'b1, TBL[i].lvl});
        chk(mask_o === TBL[i].lvl && sup_o === 1'b1, "R4 mask raised", {sup_o, mask_o}, {1'b1, TBL[i].lvl});
        chk(ssp_sel_o === 1'b1, "R11 ssp in ack", ssp_sel_o, 1);
        @(negedge clk);
        boundary_i = 1'b0;
        {ack_vec_i, ack_auto_i, ack_none_i} = TBL[i].resp;
        ack_vnum_i = TBL[i].avn;
        tick();
        chk(push_req_o === 1'b1 && ack_o === 1'b0, "R12 push after ack", push_req_o, 1);
        chk(push_sr_o === {1'b0, TBL[i].mask}, "R4 saved status", push_sr_o, {1'b0, TBL[i].mask});
        @(negedge clk);
        {ack_vec_i, ack_auto_i, ack_none_i} = 3'b000;
        finish_vec(TBL[i].evn, "R5");
      end else begin
        chk(ack_o === 1'b0 && push_req_o === 1'b0, "R2 masked level ignored", ack_o, 0);
        chk(mask_o === TBL[i].mask && sup_o === 1'b0, "R2 status kept", {sup_o, mask_o}, {1'b0, TBL[i].mask});
      end
      @(negedge clk);
      boundary_i = 1'b0; ipl_i = 3'd0;
    end

    // R9 nothing taken without boundary
    do_rte(4'b0000);
    @(negedge clk);
    ipl_i = 3'd5; boundary_i = 1'b0;
    tick();
    chk(ack_o === 1'b0 && mask_o === 3'd0, "R9 level ignored off boundary", ack_o, 0);
    @(negedge clk);
    ipl_i = 3'd0; exc_req_i = 1'b1; exc_vec_i = 8'd3;
    tick();
    chk(push_req_o === 1'b0 && sup_o === 1'b0, "R9 fault ignored off boundary", push_req_o, 0);
    @(negedge clk);
    exc_req_i = 1'b0;

    // R3 level 7 ignores mask, edge only
    do_rte(4'b0111);
    @(negedge clk);
    ipl_i = 3'd7; boundary_i = 1'b1;
    tick();
    chk(ack_o === 1'b1 && ack_lvl_o === 3'd7, "R3 level 7 past mask 7", ack_lvl_o, 7);
    @(negedge clk);
    boundary_i = 1'b0; ack_auto_i = 1'b1;
    tick();
    chk(push_sr_o === 4'b0111, "R4 saved status lvl7", push_sr_o, 4'b0111);
    @(negedge clk);
    ack_auto_i = 1'b0;
    finish_vec(8'd31, "R5 autovector 7");
    do_rte(4'b0000);
    @(negedge clk);
    boundary_i = 1'b1;
    tick();
    chk(ack_o === 1'b0, "R3 held level 7 not retaken", ack_o, 0);
    @(negedge clk);
    boundary_i = 1'b0; ipl_i = 3'd0;
    tick();
    @(negedge clk);
    ipl_i = 3'd7; boundary_i = 1'b1;
    tick();
    chk(ack_o === 1'b1 && ack_lvl_o === 3'd7, "R3 level 7 retaken after drop", ack_o, 1);
    @(negedge clk);
    boundary_i = 1'b0; ack_none_i = 1'b1;
    tick();
    @(negedge clk);
    ack_none_i = 1'b0; ipl_i = 3'd0;
    finish_vec(8'd24, "R5 spurious");

    // R7 trap
    do_rte(4'b0011);
    @(negedge clk);
    trap_req_i = 1'b1; trap_num_i = 4'd5; boundary_i = 1'b1;
    tick();
    chk(push_req_o === 1'b1 && ack_o === 1'b0, "R7 trap goes to push", {push_req_o, ack_o}, 2'b10);
    chk(sup_o === 1'b1 && mask_o === 3'd3, "R7 trap keeps mask", {sup_o, mask_o}, 4'b1011);
    chk(push_sr_o === 4'b0011, "R7 trap saved status", push_sr_o, 4'b0011);
    chk(ssp_sel_o === 1'b1, "R11 ssp in push", ssp_sel_o, 1);
    @(negedge clk);
    trap_req_i = 1'b0; boundary_i = 1'b0;
    finish_vec(8'd37, "R7 trap vector");

    // R8 ordering, R12 push hold
    do_rte(4'b0000);
    @(negedge clk);
    exc_req_i = 1'b1; exc_vec_i = 8'd4; trap_req_i = 1'b1; trap_num_i = 4'd2;
    ipl_i = 3'd6; boundary_i = 1'b1;
    tick();
    chk(push_req_o === 1'b1 && ack_o === 1'b0 && mask_o === 3'd0, "R8 fault first", {push_req_o, ack_o, mask_o}, 5'b10000);
    @(negedge clk);
    exc_req_i = 1'b0; trap_req_i = 1'b0; ipl_i = 3'd0; boundary_i = 1'b0;
    tick();
    chk(push_req_o === 1'b1 && vec_valid_o === 1'b0, "R12 push held 1", push_req_o, 1);
    tick();
    chk(push_req_o === 1'b1 && vec_valid_o === 1'b0, "R12 push held 2", push_req_o, 1);
    finish_vec(8'd4, "R8 fault vector");

    // R8 trap over level
    do_rte(4'b0000);
    @(negedge clk);
    trap_req_i = 1'b1; trap_num_i = 4'd15; ipl_i = 3'd6; boundary_i = 1'b1;
    tick();
    chk(ack_o === 1'b0 && push_req_o === 1'b1, "R8 trap over level", ack_o, 0);
    @(negedge clk);
    trap_req_i = 1'b0; ipl_i = 3'd0; boundary_i = 1'b0;
    finish_vec(8'd47, "R8 trap 15 vector");

    // R10 rte wins over request in same cycle
    do_rte(4'b0101);
    @(negedge clk);
    rte_i = 1'b1; rte_sr_i = 4'b1010; exc_req_i = 1'b1; exc_vec_i = 8'd9; boundary_i = 1'b1;
    tick();
    chk(push_req_o === 1'b0, "R10 request dropped with rte", push_req_o, 0);
    chk(sup_o === 1'b1 && mask_o === 3'd2, "R10 status restored", {sup_o, mask_o}, 4'b1010);
    @(negedge clk);
    rte_i = 1'b0; exc_req_i = 1'b0; boundary_i = 1'b0;
    do_rte(4'b0000);
    tick();
    chk(sup_o === 1'b0 && ssp_sel_o === 1'b0, "R11 user stack after rte", {sup_o, ssp_sel_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule